// File: doc/BRIEF.md
# Trace RAM Word Unpacker

This block sits between the read side of a trace capture memory and the trace decoder. Each 32-bit word that comes out of the memory packs one, two or three trace frames, depending on how wide the trace port was when the data was captured. The block takes one word at a time on a valid/ready input. It splits the word into frames and delivers them one by one, lowest bit field first, on a registered valid/ready output.

Every frame carries a 3-bit pipeline status, a packet field zero-extended to 16 bits, a sync flag and a trigger flag. A status value of 3'b110 acts as an escape code. For such a frame the block replaces the status with the low three bits of the packet and raises the trigger flag. The port-width select is treated as static, but the block samples it together with each word, so every word is unpacked with the width that was present when it was accepted.

Top module: `trace_unpacker`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0 and `in_ready` is 1.
- R2: `width_sel` is sampled when a word is accepted. 2'b00 selects the 4-bit layout (three frames per word), 2'b01 selects the 8-bit layout (two frames), and 2'b10 or 2'b11 select the 16-bit layout (one frame). Changing `width_sel` while a word is being unpacked has no effect on that word's frames.
- R3: In the 16-bit layout the only frame takes status from word bits [2:0], packet from [18:3] and sync from bit 19.
- R4: In the 8-bit layout, frame 0 takes status [2:0], packet [10:3] and sync 11. Frame 1 takes status [14:12], packet [22:15] and sync 23.
- R5: In the 4-bit layout, frame k (k = 0, 1, 2) uses the byte at bit 8k: status from its bits [2:0], packet from its bits [6:3] and sync from its bit 7.
- R6: Frames of one word leave in ascending bit order: frame 0 first, then frame 1, then frame 2.
- R7: `out_packet` bits above the packet width of the active layout are 0. Word bits outside every field of the active layout do not affect any output.
- R8: When a frame's raw status equals 3'b110, `out_status` equals `out_packet[2:0]` and `out_trigger` is 1. Otherwise `out_status` is the raw status and `out_trigger` is 0.
- R9: While `out_valid` is 1 and `out_ready` is 0, all frame outputs hold their values on the next cycle and `out_valid` stays 1.
- R10: `in_ready` is 0 while any frame of the current word is not yet accepted. It returns to 1 no earlier than the cycle in which the last frame is accepted, and a word accepted by the handshake produces exactly the number of frames set in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| width_sel | input | 2 | Trace port width select, sampled with each word |
| in_valid | input | 1 | Input word is valid |
| in_word | input | 32 | Word read from trace memory |
| in_ready | output | 1 | Block can accept a word this cycle |
| out_valid | output | 1 | Output frame is valid |
| out_ready | input | 1 | Consumer accepts the frame this cycle |
| out_status | output | 3 | Pipeline status after trigger escape handling |
| out_packet | output | 16 | Packet field, zero-extended |
| out_sync | output | 1 | Trace sync flag of the frame |
| out_trigger | output | 1 | Frame carried the trigger escape |

## Verification
The bench uses the default parameters, with a 32-bit word and the escape code 3'b110. At this size all four width-select codes can be swept, and every one of the eight status codes can be placed in every frame slot, so the escape path is exercised in each slot of each layout. The words are filled with pseudo-random packets, plus all-zero and all-one words, which makes the unused upper word bits visible to the zero-extension check. The consumer is run both fully ready and with pseudo-random stalls. Frames are therefore checked under backpressure, in-flight changes of the width select are applied, and the input-ready gating is compared against the frame count of each word.

// File: rtl/tu_pkg.sv
package tu_pkg;

  localparam int TU_ST_W  = 3;
  localparam int TU_PKT_W = 16;
  localparam int TU_IDX_W = 2;

  typedef enum logic [1:0] {
    TU_PORT4  = 2'b00,
    TU_PORT8  = 2'b01,
    TU_PORT16 = 2'b10,
    TU_PORTX  = 2'b11
  } tu_width_e;

  typedef struct packed {
    logic [TU_ST_W-1:0]  status;
    logic [TU_PKT_W-1:0] packet;
    logic                sync;
    logic                trig;
  } tu_frame_t;

  // frames carried by one word for a given width code
  function automatic logic [TU_IDX_W-1:0] tu_frames(input logic [1:0] m);
    case (m)
      TU_PORT4: tu_frames = 2'd3;
      TU_PORT8: tu_frames = 2'd2;
      default:  tu_frames = 2'd1;
    endcase
  endfunction

  // packet width in bits for a given width code
  function automatic logic [4:0] tu_pkt_bits(input logic [1:0] m);
    case (m)
      TU_PORT4: tu_pkt_bits = 5'd4;
      TU_PORT8: tu_pkt_bits = 5'd8;
      default:  tu_pkt_bits = 5'd16;
    endcase
  endfunction

  // bit offset of a frame slot inside the word
  function automatic logic [4:0] tu_slot_base(input logic [1:0] m,
                                              input logic [TU_IDX_W-1:0] idx);
    case (m)
      TU_PORT4: tu_slot_base = 5'(idx) << 3;
      TU_PORT8: tu_slot_base = (idx == 2'd0) ? 5'd0 : 5'd12;
      default:  tu_slot_base = 5'd0;
    endcase
  endfunction

endpackage

// File: rtl/tu_slot_extract.sv
module tu_slot_extract
  import tu_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0]   word,
  input  logic [1:0]          mode,
  input  logic [TU_IDX_W-1:0] idx,
  output tu_frame_t           raw
);

  localparam int MASK_W = TU_PKT_W + 1;

  logic [WORD_W-1:0]   shifted;
  logic [4:0]          base;
  logic [4:0]          pbits;
  logic [4:0]          sync_pos;
  logic [MASK_W-1:0]   mask_full;

  always_comb begin
    base      = tu_slot_base(mode, idx);
    pbits     = tu_pkt_bits(mode);
    shifted   = word >> base;
    sync_pos  = 5'(TU_ST_W) + pbits;
    mask_full = (MASK_W'(1) << pbits) - MASK_W'(1);
    raw.status = shifted[TU_ST_W-1:0];
    raw.packet = shifted[TU_ST_W +: TU_PKT_W] & mask_full[TU_PKT_W-1:0];
    raw.sync   = shifted[sync_pos];
    raw.trig   = 1'b0;
  end

endmodule

// File: rtl/tu_trig_escape.sv
module tu_trig_escape
  import tu_pkg::*;
#(
  parameter logic [TU_ST_W-1:0] TRIG_CODE = 3'b110
) (
  input  tu_frame_t raw,
  output tu_frame_t fixed
);

  always_comb begin
    fixed = raw;
    if (raw.status == TRIG_CODE) begin
      fixed.status = raw.packet[TU_ST_W-1:0];
      fixed.trig   = 1'b1;
    end
  end

endmodule

// File: rtl/tu_frame_seq.sv
module tu_frame_seq
  import tu_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [1:0]          width_sel,
  input  logic                out_valid,
  input  logic                out_ready,
  output logic                in_ready,
  output logic                take,
  output logic                load,
  output logic                busy,
  output logic [TU_IDX_W-1:0] idx,
  output logic [1:0]          mode_q
);

  logic slot_free;
  logic last;

  assign slot_free = !out_valid || out_ready;
  assign in_ready  = !busy && slot_free;
  assign take      = in_valid && in_ready;
  assign load      = busy && slot_free;
  assign last      = (idx == tu_frames(mode_q) - 2'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      idx    <= '0;
      mode_q <= TU_PORT16;
    end else if (take) begin
      busy   <= 1'b1;
      idx    <= '0;
      mode_q <= width_sel;
    end else if (load) begin
      if (last) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx  <= idx + 2'd1;
      end
    end
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy |-> (idx < tu_frames(mode_q))); // R2

  AST_PENDING_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
    (busy && load && !last) |=> !in_ready); // R10

endmodule

// File: rtl/trace_unpacker.sv
module trace_unpacker
  import tu_pkg::*;
#(
  parameter int                 WORD_W    = 32,
  parameter logic [TU_ST_W-1:0] TRIG_CODE = 3'b110
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          width_sel,
  input  logic                in_valid,
  input  logic [WORD_W-1:0]   in_word,
  output logic                in_ready,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [TU_ST_W-1:0]  out_status,
  output logic [TU_PKT_W-1:0] out_packet,
  output logic                out_sync,
  output logic                out_trigger
);

  logic                take;
  logic                load;
  logic                busy;
  logic [TU_IDX_W-1:0] idx;
  logic [1:0]          mode_q;
  logic [WORD_W-1:0]   word_q;
  tu_frame_t           raw_frame;
  tu_frame_t           esc_frame;
  tu_frame_t           out_q;

  tu_frame_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .width_sel (width_sel),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .take      (take),
    .load      (load),
    .busy      (busy),
    .idx       (idx),
    .mode_q    (mode_q)
  );

  always_ff @(posedge clk) begin
    if (rst) word_q <= '0;
    else if (take) word_q <= in_word;
  end

  tu_slot_extract #(.WORD_W(WORD_W)) u_extract (
    .word (word_q),
    .mode (mode_q),
    .idx  (idx),
    .raw  (raw_frame)
  );

  tu_trig_escape #(.TRIG_CODE(TRIG_CODE)) u_escape (
    .raw   (raw_frame),
    .fixed (esc_frame)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_q     <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_q     <= esc_frame;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign out_status  = out_q.status;
  assign out_packet  = out_q.packet;
  assign out_sync    = out_q.sync;
  assign out_trigger = out_q.trig;

  // frames handed out since the last accepted word
  logic [1:0] emit_cnt;
  logic       seen_word;
  always_ff @(posedge clk) begin
    if (rst) begin
      emit_cnt  <= '0;
      seen_word <= 1'b0;
    end else if (in_valid && in_ready) begin
      emit_cnt  <= '0;
      seen_word <= 1'b1;
    end else if (out_valid && out_ready) begin
      emit_cnt  <= emit_cnt + 2'd1;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_status) && $stable(out_packet) && $stable(out_sync) && $stable(out_trigger))); // R9

  AST_TRIG_CARRIES_STATUS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_trigger) |-> (out_packet[TU_ST_W-1:0] == out_status)); // R8

  AST_PLAIN_NOT_CODE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_trigger) |-> (out_status != TRIG_CODE)); // R8

  AST_WORD_DRAINED: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && seen_word) |-> (({1'b0, emit_cnt} + 3'(out_valid && out_ready)) == {1'b0, tu_frames(mode_q)})); // R10

endmodule

// File: tb/test_trace_unpacker.sv
`timescale 1ns/1ps
module test_trace_unpacker;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  width_sel = 2'b00;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [2:0]  out_status;
  logic [15:0] out_packet;
  logic        out_sync;
  logic        out_trigger;

  int n_checks = 0;
  int n_fails  = 0;
  logic [31:0] rng = 32'h1bad_5eed;

  always #2.5 clk = ~clk;

  trace_unpacker i_trace_unpacker (
    .clk         (clk),
    .rst         (rst),
    .width_sel   (width_sel),
    .in_valid    (in_valid),
    .in_word     (in_word),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_status  (out_status),
    .out_packet  (out_packet),
    .out_sync    (out_sync),
    .out_trigger (out_trigger)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  function automatic logic [31:0] next_rng(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  function automatic int frames_of(input logic [1:0] m);
    return (m == 2'b00) ? 3 : (m == 2'b01) ? 2 : 1;
  endfunction

  // expected frame per R3, R4, R5 and R8
  task automatic expect_frame(input logic [1:0] m, input logic [31:0] w, input int f,
                              output logic [2:0] st, output logic [15:0] pk,
                              output logic sy, output logic tr);
    int b;
    if (m == 2'b00) begin
      b  = 8 * f;
      st = w[b +: 3];
      pk = {12'b0, w[b+3 +: 4]};
      sy = w[b+7];
    end else if (m == 2'b01) begin
      b  = 12 * f;
      st = w[b +: 3];
      pk = {8'b0, w[b+3 +: 8]};
      sy = w[b+11];
    end else begin
      st = w[2:0];
      pk = w[18:3];
      sy = w[19];
    end
    tr = (st == 3'b110);
    if (tr) st = pk[2:0];
  endtask

  task automatic run_word(input logic [1:0] m, input logic [31:0] w, input bit stall);
    int nf;
    logic [2:0]  est;
    logic [15:0] epk;
    logic        esy;
    logic        etr;
    logic        held;
    logic [20:0] held_v;
    string       tag;
    nf = frames_of(m);
    tag = (m == 2'b00) ? "R5" : (m == 2'b01) ? "R4" : "R3";
    @(negedge clk);
    width_sel = m;
    in_word   = w;
    in_valid  = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    in_valid  = 1'b0;
    in_word   = ~w;
    width_sel = ~m; // R2: must not disturb the word in flight
    for (int f = 0; f < nf; f++) begin
      bit got;
      got  = 1'b0;
      held = 1'b0;
      held_v = '0;
      while (!got) begin
        @(negedge clk);
        rng = next_rng(rng);
        out_ready = stall ? rng[7] : 1'b1;
        #1;
        if (out_valid) begin
          if (held)
            check({out_status, out_packet, out_sync, out_trigger} == held_v, "R9",
                  "held frame", 32'({out_status, out_packet, out_sync, out_trigger}), 32'(held_v));
          check(in_ready == (out_ready && (f == nf - 1)), "R10", "in_ready with frame pending",
                32'(in_ready), 32'(out_ready && (f == nf - 1)));
          if (out_ready) begin
            expect_frame(m, w, f, est, epk, esy, etr);
            check({out_status, out_packet[3:0], out_sync} == {est, epk[3:0], esy},
                  etr ? "R8" : tag, "frame fields (R6 order)",
                  32'({out_status, out_packet[3:0], out_sync}), 32'({est, epk[3:0], esy}));
            check(out_packet == epk, "R7", "packet zero-extended", 32'(out_packet), 32'(epk));
            check(out_trigger == etr, "R8", "trigger flag", 32'(out_trigger), 32'(etr));
            got = 1'b1;
          end else begin
            held   = 1'b1;
            held_v = {out_status, out_packet, out_sync, out_trigger};
          end
        end else begin
          check(in_ready == 1'b0, "R10", "in_ready while loading", 32'(in_ready), 32'd0);
        end
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(out_valid == 1'b0, "R1", "out_valid after reset", 32'(out_valid), 32'd0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", 32'(in_ready), 32'd1);
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 8; s++) begin
        for (int st = 0; st < 2; st++) begin
          logic [31:0] w;
          rng = next_rng(rng);
          w = rng;
          if (m == 0) begin
            w[2:0] = 3'(s); w[10:8] = 3'(s + 1); w[18:16] = 3'(s + 2);
          end else if (m == 1) begin
            w[2:0] = 3'(s); w[14:12] = 3'(s + 3);
          end else begin
            w[2:0] = 3'(s);
          end
          run_word(2'(m), w, st[0]);
        end
      end
      run_word(2'(m), 32'h0000_0000, 1'b0);
      run_word(2'(m), 32'hffff_ffff, 1'b1);
      run_word(2'(m), 32'hdead_beef, 1'b1);
    end
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL R10 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

endmodule